// File: doc/BRIEF.md
# Write-Protected Control Register Bank with Bit-Operation Aliases

A bank of 32-bit control registers on a single-cycle synchronous bus. Every register has a fixed protection mask. A bit whose mask bit is 1 cannot be changed by any bus write. A bit whose mask bit is 0 follows the operation the write selects. Selected registers also answer at three extra word addresses directly above their base. Those addresses set, clear or toggle the written bits instead of replacing the whole word. This lets software change one field without a read-modify-write sequence.

The base address, mask, reset value and alias flag of each register are parameters. The default table has six registers:

| Index | Base (word address) | Aliases | Mask | Reset value |
|---|---|---|---|---|
| 0 | 0x00 | no | 0x00000000 | 0x12345678 |
| 1 | 0x01 | no | 0xFFFFFFFF | 0xA5A5A5A5 |
| 2 | 0x02 | no | 0xF01FEF80 | 0x00000000 |
| 3 | 0x04 | yes, 0x05..0x07 | 0xFFF60F80 | 0x80001063 |
| 4 | 0x08 | yes, 0x09..0x0B | 0xC0000000 | 0x00000012 |
| 5 | 0x0C | yes, 0x0D..0x0F | 0x40404040 | 0x0F1F2F3F |

Register 4 is a fraction register. Register 5 is a divider register with four byte-wide fields. Address 0x03 and addresses 0x10 through 0x3F are unmapped.

Top module: `maskreg_bank`

## Requirements
- R1: While rst_ni is low, every register loads its reset value from the table, including bits its mask protects.
- R2: A write to a base address stores (old & mask) | (wdata & ~mask).
- R3: A write to base+1 of a register with aliases stores old | (wdata & ~mask).
- R4: A write to base+2 of a register with aliases stores old & ~(wdata & ~mask).
- R5: A write to base+3 of a register with aliases stores old ^ (wdata & ~mask).
- R6: A register with an all-zero mask (register 0) takes every written bit. A register with an all-ones mask (register 1) never changes after reset.
- R7: In the default table, the fraction register (0x08) protects only bits 31:30. The divider register (0x0C) protects only bit 6 of each byte.
- R8: A register without aliases changes only on a write to its own base address. A write to 0x03, which lies directly above register 2, leaves register 2 unchanged.
- R9: A read at base+1, base+2 or base+3 of a register with aliases returns the value of that register.
- R10: A write to an unmapped address changes no register. A read from an unmapped address returns zero.
- R11: rdata_o shows the register selected by addr_i one clock after the address is presented. A write takes effect on the clock edge where we_i is high. A read in that same cycle therefore returns the value from before the write.
- R12: When we_i is low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 6 | Word address for both reads and writes |
| we_i | input | 1 | Write enable; the write happens on the clock edge where it is high |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |

## Verification
The assertions check on every cycle that:
- no register ever changes a protected bit;
- every register holds its value while no write is in progress;
- each plain, set, clear and toggle write gives exactly the masked result on the next cycle;
- read data follows the addressed register with one cycle of latency, and is zero for unmapped addresses.

Some behaviour only the bench scenarios can show:
- reset loads the table values, both at start-up and when reset is applied in the middle of a run;
- the default masks protect the intended fraction and divider bits;
- a read in the same cycle as a write returns the old value;
- the address just above a register without aliases has no effect on that register.

// File: rtl/maskreg_bank_pkg.sv
package maskreg_bank_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_WRITE = 3'd1,
    OP_SET   = 3'd2,
    OP_CLR   = 3'd3,
    OP_TOG   = 3'd4
  } wr_op_e;

  localparam int DEF_NUM_REGS = 6;
  localparam int DEF_ADDR_W   = 6;
  localparam int DEF_DATA_W   = 32;

  // index 5 first
  localparam logic [DEF_NUM_REGS-1:0][DEF_ADDR_W-1:0] DEF_BASE =
    {6'h0C, 6'h08, 6'h04, 6'h02, 6'h01, 6'h00};
  localparam logic [DEF_NUM_REGS-1:0][DEF_DATA_W-1:0] DEF_MASK =
    {32'h4040_4040, 32'hC000_0000, 32'hFFF6_0F80,
     32'hF01F_EF80, 32'hFFFF_FFFF, 32'h0000_0000};
  localparam logic [DEF_NUM_REGS-1:0][DEF_DATA_W-1:0] DEF_RESET =
    {32'h0F1F_2F3F, 32'h0000_0012, 32'h8000_1063,
     32'h0000_0000, 32'hA5A5_A5A5, 32'h1234_5678};
  localparam logic [DEF_NUM_REGS-1:0] DEF_ALIAS = 6'b111000;

endpackage

// File: rtl/maskreg_decode.sv
module maskreg_decode
  import maskreg_bank_pkg::*;
#(
  parameter int NUM_REGS = DEF_NUM_REGS,
  parameter int ADDR_W   = DEF_ADDR_W,
  parameter logic [NUM_REGS-1:0][ADDR_W-1:0] REG_BASE = DEF_BASE,
  parameter logic [NUM_REGS-1:0] REG_ALIAS = DEF_ALIAS
) (
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       we_i,
  output wr_op_e [NUM_REGS-1:0]      op_o,
  output logic [NUM_REGS-1:0]        rsel_o
);

  localparam logic [ADDR_W-1:0] OFF_SET = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFF_CLR = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFF_TOG = ADDR_W'(3);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    logic [ADDR_W-1:0] off;
    assign off = addr_i - REG_BASE[i];

    if (REG_ALIAS[i]) begin : g_alias
      assign rsel_o[i] = (off <= OFF_TOG);
      always_comb begin
        op_o[i] = OP_NONE;
        if (we_i) begin
          unique case (off)
            '0:      op_o[i] = OP_WRITE;
            OFF_SET: op_o[i] = OP_SET;
            OFF_CLR: op_o[i] = OP_CLR;
            OFF_TOG: op_o[i] = OP_TOG;
            default: op_o[i] = OP_NONE;
          endcase
        end
      end
    end else begin : g_plain
      assign rsel_o[i] = (off == '0);
      assign op_o[i]   = (we_i && off == '0) ? OP_WRITE : OP_NONE;
    end
  end

endmodule

// File: rtl/maskreg_cell.sv
module maskreg_cell
  import maskreg_bank_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W,
  parameter logic [DATA_W-1:0] MASK  = '0,
  parameter logic [DATA_W-1:0] RESET = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  wr_op_e            op_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);

  logic [DATA_W-1:0] eff, q_d;

  assign eff = wdata_i & ~MASK;

  always_comb begin
    unique case (op_i)
      OP_WRITE: q_d = (q_o & MASK) | eff;
      OP_SET:   q_d = q_o | eff;
      OP_CLR:   q_d = q_o & ~eff;
      OP_TOG:   q_d = q_o ^ eff;
      default:  q_d = q_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RESET;
    else         q_o <= q_d;
  end

endmodule

// File: rtl/maskreg_rdmux.sv
module maskreg_rdmux #(
  parameter int NUM_REGS = 6,
  parameter int DATA_W   = 32
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_REGS-1:0]              rsel_i,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  regs_i,
  output logic [DATA_W-1:0]                rdata_o
);

  logic [DATA_W-1:0] rd_d;

  // AND-OR select; decode keeps rsel one-hot or empty
  always_comb begin
    rd_d = '0;
    for (int i = 0; i < NUM_REGS; i++)
      rd_d |= regs_i[i] & {DATA_W{rsel_i[i]}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_d;
  end

endmodule

// File: rtl/maskreg_bank.sv
module maskreg_bank
  import maskreg_bank_pkg::*;
#(
  parameter int NUM_REGS = DEF_NUM_REGS,
  parameter int ADDR_W   = DEF_ADDR_W,
  parameter int DATA_W   = DEF_DATA_W,
  parameter logic [NUM_REGS-1:0][ADDR_W-1:0] REG_BASE  = DEF_BASE,
  parameter logic [NUM_REGS-1:0][DATA_W-1:0] REG_MASK  = DEF_MASK,
  parameter logic [NUM_REGS-1:0][DATA_W-1:0] REG_RESET = DEF_RESET,
  parameter logic [NUM_REGS-1:0]             REG_ALIAS = DEF_ALIAS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  wr_op_e [NUM_REGS-1:0]            reg_op;
  logic   [NUM_REGS-1:0]            rsel;
  logic   [NUM_REGS-1:0][DATA_W-1:0] reg_q;

  maskreg_decode #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W),
    .REG_BASE (REG_BASE),
    .REG_ALIAS(REG_ALIAS)
  ) u_dec (
    .addr_i (addr_i),
    .we_i   (we_i),
    .op_o   (reg_op),
    .rsel_o (rsel)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    maskreg_cell #(
      .DATA_W(DATA_W),
      .MASK  (REG_MASK[i]),
      .RESET (REG_RESET[i])
    ) u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .op_i   (reg_op[i]),
      .wdata_i(wdata_i),
      .q_o    (reg_q[i])
    );
  end

  maskreg_rdmux #(
    .NUM_REGS(NUM_REGS),
    .DATA_W  (DATA_W)
  ) u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rsel_i (rsel),
    .regs_i (reg_q),
    .rdata_o(rdata_o)
  );

endmodule

// File: rtl/maskreg_bank_chk.sv
module maskreg_bank_chk #(
  parameter int NUM_REGS = 6,
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 32,
  parameter logic [NUM_REGS-1:0][ADDR_W-1:0] REG_BASE  = '0,
  parameter logic [NUM_REGS-1:0][DATA_W-1:0] REG_MASK  = '0,
  parameter logic [NUM_REGS-1:0]             REG_ALIAS = '0
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic [ADDR_W-1:0]               addr_i,
  input logic                            we_i,
  input logic [DATA_W-1:0]               wdata_i,
  input logic [DATA_W-1:0]               rdata_o,
  input logic [NUM_REGS-1:0][DATA_W-1:0] reg_q,
  input logic [NUM_REGS-1:0]             rsel
);

  p_rsel_exclusive_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rsel));

  p_unmapped_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsel == '0) |=> (rdata_o == '0));

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_chk
    localparam logic [DATA_W-1:0] M = REG_MASK[i];
    localparam logic [ADDR_W-1:0] B = REG_BASE[i];

    p_protected_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i |=> ((reg_q[i] & M) == ($past(reg_q[i]) & M)));

    p_idle_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !we_i |=> $stable(reg_q[i]));

    p_plain_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == B) |=>
        (reg_q[i] == (($past(reg_q[i]) & M) | ($past(wdata_i) & ~M))));

    p_read_base_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (addr_i == B) |=> (rdata_o == $past(reg_q[i])));

    if (REG_ALIAS[i]) begin : g_alias
      p_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && addr_i == B + ADDR_W'(1)) |=>
          (reg_q[i] == ($past(reg_q[i]) | ($past(wdata_i) & ~M))));

      p_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && addr_i == B + ADDR_W'(2)) |=>
          (reg_q[i] == ($past(reg_q[i]) & ~($past(wdata_i) & ~M))));

      p_tog_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && addr_i == B + ADDR_W'(3)) |=>
          (reg_q[i] == ($past(reg_q[i]) ^ ($past(wdata_i) & ~M))));

      p_alias_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_i == B + ADDR_W'(1) || addr_i == B + ADDR_W'(2) ||
         addr_i == B + ADDR_W'(3)) |=> (rdata_o == $past(reg_q[i])));
    end
  end

endmodule

bind maskreg_bank maskreg_bank_chk #(
  .NUM_REGS (NUM_REGS),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .REG_BASE (REG_BASE),
  .REG_MASK (REG_MASK),
  .REG_ALIAS(REG_ALIAS)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .we_i   (we_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .reg_q  (reg_q),
  .rsel   (rsel)
);

// File: tb/sim_maskreg_bank.sv
`timescale 1ns/1ps
module sim_maskreg_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  maskreg_bank u0 (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .addr_i (addr),
    .we_i   (we),
    .wdata_i(wdata),
    .rdata_o(rdata)
  );

  typedef struct packed {
    logic        we;
    logic [5:0]  waddr;
    logic [31:0] wdata;
    logic [5:0]  raddr;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 6'h00, 32'hDEADBEEF, 6'h00, 32'hDEADBEEF, 4'd2},  // R2, R6 open reg
    '{1'b1, 6'h01, 32'h00000000, 6'h01, 32'hA5A5A5A5, 4'd6},  // R6 read-only
    '{1'b1, 6'h02, 32'hFFFFFFFF, 6'h02, 32'h0FE0107F, 4'd2},  // R2 partial mask
    '{1'b1, 6'h08, 32'hFFFFFFFF, 6'h08, 32'h3FFFFFFF, 4'd7},  // R7 fraction
    '{1'b1, 6'h0B, 32'hFFFFFFFF, 6'h08, 32'h00000000, 4'd5},  // R5 toggle
    '{1'b1, 6'h09, 32'hC0000005, 6'h0A, 32'h00000005, 4'd3},  // R3 set, R9
    '{1'b1, 6'h0A, 32'h00000001, 6'h08, 32'h00000004, 4'd4},  // R4 clear
    '{1'b1, 6'h0C, 32'hFFFFFFFF, 6'h0C, 32'hBFBFBFBF, 4'd7},  // R7 divider
    '{1'b1, 6'h0F, 32'hFFFFFFFF, 6'h0D, 32'h00000000, 4'd5},  // R5, R9
    '{1'b1, 6'h05, 32'hFFFFFFFF, 6'h04, 32'h8009F07F, 4'd3},  // R3 keeps bit31
    '{1'b1, 6'h06, 32'hFFFFFFFF, 6'h07, 32'h80000000, 4'd4},  // R4, R9
    '{1'b1, 6'h03, 32'hFFFFFFFF, 6'h02, 32'h0FE0107F, 4'd8},  // R8
    '{1'b1, 6'h03, 32'hFFFFFFFF, 6'h03, 32'h00000000, 4'd10}, // R10
    '{1'b0, 6'h00, 32'h11111111, 6'h00, 32'hDEADBEEF, 4'd12}, // R12
    '{1'b1, 6'h2A, 32'h12345678, 6'h2A, 32'h00000000, 4'd10}  // R10
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic en);
    @(negedge clk);
    addr = a; wdata = d; we = en;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a; we = 1'b0;
    @(negedge clk);
    v = rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: power-up contents
    rd(6'h00, v); check("R1 reg0", v, 32'h12345678);
    rd(6'h01, v); check("R1 reg1", v, 32'hA5A5A5A5);
    rd(6'h02, v); check("R1 reg2", v, 32'h00000000);
    rd(6'h04, v); check("R1 reg3", v, 32'h80001063);
    rd(6'h08, v); check("R1 reg4", v, 32'h00000012);
    rd(6'h0C, v); check("R1 reg5", v, 32'h0F1F2F3F);

    for (int i = 0; i < NVEC; i++) begin
      wr(VECS[i].waddr, VECS[i].wdata, VECS[i].we);
      rd(VECS[i].raddr, v);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), v, VECS[i].exp);
    end

    // R11: read in the write cycle sees old value, next sees new
    @(negedge clk);
    addr = 6'h00; wdata = 32'hCAFEF00D; we = 1'b1;
    @(negedge clk);
    check("R11 same-cycle read", rdata, 32'hDEADBEEF);
    we = 1'b0;
    @(negedge clk);
    check("R11 after write", rdata, 32'hCAFEF00D);
    addr = 6'h0C;
    @(negedge clk);
    check("R11 one-cycle latency", rdata, 32'h00000000);

    // R1: reset in the middle of a run
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd(6'h00, v); check("R1 re-reset reg0", v, 32'h12345678);
    rd(6'h08, v); check("R1 re-reset reg4", v, 32'h00000012);
    rd(6'h0D, v); check("R1 re-reset reg5 alias", v, 32'h0F1F2F3F);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule